// File: doc/BRIEF.md
# Shared Bus Ownership Handshake Unit

This unit sits between a processor core and a shared external bus that several masters use. The core raises a level request whenever it needs external accesses. It also raises a lock flag for the whole of a read-modify-write sequence. The unit obtains the bus from an external arbiter and reports ownership back to the core. Toward the bus it drives a request line, a busy line that marks the current owner, and a lock line that a memory controller can use to stall other masters.

Ownership is held by the busy line, not by the request line. Once the unit owns the bus it drops its request. While a locked sequence runs, it keeps the busy line high even if the arbiter withdraws the grant. When the core goes quiet while the grant is still present, the unit keeps the bus parked on itself. A later access then starts at once, without a new request. An optional synchronizer depth can be set on the two sampled bus inputs. A build option can turn parking off.

Top module: `bus_owner_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `bus_req_out`, `bus_busy_out`, `bus_lock_out` and `core_grant` are all 0. Every signal is active-high.
- R2: From idle, `core_req`=1 raises `bus_req_out` at the next clock edge, and `core_grant` stays 0 until ownership is taken.
- R3: Ownership is taken only at an edge where the sampled grant is 1 and the sampled external busy is 0. If the grant is present but the bus is busy, `bus_req_out` stays 1 and `bus_busy_out` stays 0.
- R4: At the edge that takes ownership, `bus_req_out` falls and both `bus_busy_out` and `core_grant` rise. `core_grant` is never 1 without `bus_busy_out`.
- R5: While owning the bus with no lock, a withdrawn grant drops `bus_busy_out` and `core_grant` at the next edge. `bus_req_out` returns to the value of `core_req`.
- R6: With the grant present, `core_req`=1 and `core_lock`=1 while owning raises `bus_lock_out` at the next edge. `bus_lock_out` is never 1 without `bus_busy_out`.
- R7: While locked, `bus_busy_out`, `bus_lock_out` and `core_grant` stay 1 whatever the grant does, as long as `core_lock` is 1. At the edge after `core_lock` falls, `bus_lock_out` and the held `bus_busy_out` fall together if the grant is gone.
- R8: With parking enabled, `core_req`=0 while owning with the grant present gives `bus_req_out`=0, `bus_busy_out`=1 and `core_grant`=1.
- R9: While parked, `core_req`=1 resumes ownership at once. `core_grant` stays 1 and `bus_req_out` stays 0 (plus `bus_lock_out`=1 if `core_lock`=1).
- R10: While parked, a withdrawn grant drops `bus_busy_out` and `core_grant` at the next edge.
- R11: With `PARK_ENABLE`=0, `core_req`=0 while owning drops `bus_busy_out` and `core_grant` at the next edge, even if the grant stays.
- R12: `bus_req_out` and `bus_busy_out` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active-high |
| core_req | input | 1 | Core wants external accesses (level) |
| core_lock | input | 1 | Current accesses form a locked read-modify-write |
| bus_grant_in | input | 1 | Grant from the external arbiter |
| bus_busy_in | input | 1 | Busy line of the shared bus, as seen from outside |
| core_grant | output | 1 | Bus is owned; core access may proceed |
| bus_req_out | output | 1 | Request to the arbiter |
| bus_busy_out | output | 1 | This unit drives the bus as owner |
| bus_lock_out | output | 1 | Locked sequence in progress |

## Verification
The bench aims at the three places where ownership can go wrong. The first is the grant arriving while another master still holds the bus: a design that ignored the busy line would raise `bus_busy_out` too early and collide with that master. The second is the grant falling in the middle of a locked sequence: a faulty design would drop the busy line between the read and the write and let another master slip in. The third is parking: a design that mishandled it would either re-request the bus for every access or keep holding a bus whose grant has moved on. From the owned, locked and parked states it sweeps all sixteen combinations of the four inputs and compares the outputs with a table derived from the requirements. It also runs a second copy built with parking disabled.

// File: rtl/bus_owner_pkg.sv
package bus_owner_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd1,
      ST_WAIT = 3'd2,
      ST_OWN  = 3'd3,
      ST_LOCK = 3'd4,
      ST_PARK = 3'd5
   } own_state_t;

   typedef struct packed {
      logic req;
      logic busy;
      logic lock;
      logic grant;
   } bus_ctl_t;

   localparam int MAX_SYNC_STAGES = 3;

endpackage

// File: rtl/bus_owner_sync.sv
module bus_owner_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic in_bit,
   output logic out_bit
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign out_bit = in_bit;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2+1-1:0], in_bit} >> 0;
         end
         assign out_bit = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bus_owner_fsm.sv
module bus_owner_fsm
   import bus_owner_pkg::*;
#(
   parameter bit PARK_ENABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       core_req,
   input  logic       core_lock,
   input  logic       grant_s,
   input  logic       busy_s,
   output own_state_t state_q,
   output own_state_t state_d
);
   logic park_ok;

   generate
      if (PARK_ENABLE) begin : g_park
         assign park_ok = 1'b1;
      end else begin : g_nopark
         assign park_ok = 1'b0;
      end
   endgenerate

   own_state_t lost_st;
   own_state_t acq_st;
   own_state_t idle_st;

   always_comb begin
      lost_st = core_req ? ST_REQ : ST_IDLE;
      acq_st  = core_lock ? ST_LOCK : ST_OWN;
      idle_st = park_ok ? ST_PARK : ST_IDLE;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (core_req) state_d = ST_REQ;
         ST_REQ: begin
            if (!core_req)   state_d = ST_IDLE;
            else if (grant_s) state_d = busy_s ? ST_WAIT : acq_st;
         end
         ST_WAIT: begin
            if (!core_req)     state_d = ST_IDLE;
            else if (!grant_s) state_d = ST_REQ;
            else if (!busy_s)  state_d = acq_st;
         end
         ST_OWN: begin
            if (!grant_s)       state_d = lost_st;
            else if (!core_req) state_d = idle_st;
            else if (core_lock) state_d = ST_LOCK;
         end
         ST_LOCK: begin
            if (!core_lock) begin
               if (!grant_s)       state_d = lost_st;
               else if (!core_req) state_d = idle_st;
               else                state_d = ST_OWN;
            end
         end
         ST_PARK: begin
            if (!grant_s)      state_d = lost_st;
            else if (core_req) state_d = acq_st;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end
endmodule

// File: rtl/bus_owner_outs.sv
module bus_owner_outs
   import bus_owner_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  own_state_t state_d,
   output bus_ctl_t   ctl_q
);
   bus_ctl_t ctl_d;

   always_comb begin
      ctl_d.req   = (state_d == ST_REQ) || (state_d == ST_WAIT);
      ctl_d.busy  = (state_d == ST_OWN) || (state_d == ST_LOCK) || (state_d == ST_PARK);
      ctl_d.lock  = (state_d == ST_LOCK);
      ctl_d.grant = ctl_d.busy;
   end

   always_ff @(posedge clk) begin
      if (rst) ctl_q <= '0;
      else     ctl_q <= ctl_d;
   end

   AST_LOCK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      ctl_q.lock |-> ctl_q.busy); // R6
   AST_GRANT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      ctl_q.grant |-> ctl_q.busy); // R4
endmodule

// File: rtl/bus_owner_unit.sv
module bus_owner_unit
   import bus_owner_pkg::*;
#(
   parameter int SYNC_STAGES = 0,
   parameter bit PARK_ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic core_req,
   input  logic core_lock,
   input  logic bus_grant_in,
   input  logic bus_busy_in,
   output logic core_grant,
   output logic bus_req_out,
   output logic bus_busy_out,
   output logic bus_lock_out
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
         $error("bus_owner_unit: SYNC_STAGES out of range");
      end
   endgenerate

   logic       grant_s;
   logic       busy_s;
   own_state_t state_q;
   own_state_t state_d;
   bus_ctl_t   ctl_q;

   bus_owner_sync #(.STAGES(SYNC_STAGES)) i_sync_grant (
      .clk(clk), .rst(rst), .in_bit(bus_grant_in), .out_bit(grant_s));
   bus_owner_sync #(.STAGES(SYNC_STAGES)) i_sync_busy (
      .clk(clk), .rst(rst), .in_bit(bus_busy_in), .out_bit(busy_s));

   bus_owner_fsm #(.PARK_ENABLE(PARK_ENABLE)) i_fsm (
      .clk(clk), .rst(rst), .core_req(core_req), .core_lock(core_lock),
      .grant_s(grant_s), .busy_s(busy_s), .state_q(state_q), .state_d(state_d));

   bus_owner_outs i_outs (
      .clk(clk), .rst(rst), .state_d(state_d), .ctl_q(ctl_q));

   assign core_grant   = ctl_q.grant;
   assign bus_req_out  = ctl_q.req;
   assign bus_busy_out = ctl_q.busy;
   assign bus_lock_out = ctl_q.lock;

   AST_REQ_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(bus_req_out && bus_busy_out)); // R12
   AST_ACQUIRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_busy_out) |-> $past(grant_s && !busy_s)); // R3
   AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
      (bus_lock_out && core_lock) |=> (bus_busy_out && bus_lock_out)); // R7
   AST_UNLOCKED_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (bus_busy_out && !bus_lock_out && !grant_s) |=> !bus_busy_out); // R10
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> !(bus_req_out || bus_busy_out || bus_lock_out || core_grant)); // R1
endmodule

// File: tb/test_bus_owner_unit.sv
module test_bus_owner_unit;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic core_req = 1'b0, core_lock = 1'b0, bg = 1'b0, bin = 1'b0;
   logic grant_a, req_a, busy_a, lock_a;
   logic grant_b, req_b, busy_b, lock_b;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   bus_owner_unit i_bus_owner_unit (
      .clk(clk), .rst(rst), .core_req(core_req), .core_lock(core_lock),
      .bus_grant_in(bg), .bus_busy_in(bin), .core_grant(grant_a),
      .bus_req_out(req_a), .bus_busy_out(busy_a), .bus_lock_out(lock_a));

   bus_owner_unit #(.PARK_ENABLE(1'b0)) i_bus_owner_unit_nopark (
      .clk(clk), .rst(rst), .core_req(core_req), .core_lock(core_lock),
      .bus_grant_in(bg), .bus_busy_in(bin), .core_grant(grant_b),
      .bus_req_out(req_b), .bus_busy_out(busy_b), .bus_lock_out(lock_b));

   // vector order {req, busy, lock, grant}
   function automatic logic [3:0] vec_a();
      return {req_a, busy_a, lock_a, grant_a};
   endfunction

   task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%b exp=%b", tag, got, exp);
      end
   endtask

   task automatic step(input logic r, input logic l, input logic g, input logic b);
      @(negedge clk);
      core_req = r; core_lock = l; bg = g; bin = b;
      @(posedge clk);
      #1;
      total++;
      if (req_a && busy_a) begin
         bad++;
         $display("FAIL R12 got=%b exp=req and busy not both", vec_a());
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; core_req = 0; core_lock = 0; bg = 0; bin = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic go_owned();
      do_reset();
      step(1, 0, 1, 0);
      step(1, 0, 1, 0);
   endtask

   // expected outputs after one edge from OWN, LOCK or PARK
   function automatic logic [3:0] exp_after(input bit from_lock, input logic r,
                                            input logic l, input logic g);
      if (from_lock && l) return 4'b0111;
      if (!g)             return {r, 3'b000};
      if (!r)             return 4'b0101;
      if (l)              return 4'b0111;
      return 4'b0101;
   endfunction

   function automatic string tag_for(input bit from_lock, input logic r,
                                     input logic l, input logic g, input int src);
      if (from_lock && l) return "R7";
      if (!g) return (src == 2) ? "R10" : "R5";
      if (!r) return "R8";
      if (l)  return (src == 2) ? "R9" : "R6";
      return (src == 2) ? "R9" : "R4";
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      check("R1", vec_a(), 4'b0000);
      do_reset();
      #1;
      check("R1", vec_a(), 4'b0000);

      step(1, 0, 0, 0);
      check("R2", vec_a(), 4'b1000);
      step(1, 0, 0, 0);
      check("R2", vec_a(), 4'b1000);
      step(1, 0, 1, 1);
      check("R3", vec_a(), 4'b1000);
      step(1, 0, 1, 1);
      check("R3", vec_a(), 4'b1000);
      step(1, 0, 1, 0);
      check("R4", vec_a(), 4'b0101);

      // locked sequence survives grant loss, then releases BL and BB together
      step(1, 1, 1, 0);
      check("R6", vec_a(), 4'b0111);
      step(1, 1, 0, 1);
      check("R7", vec_a(), 4'b0111);
      step(1, 1, 0, 0);
      check("R7", vec_a(), 4'b0111);
      step(1, 0, 0, 0);
      check("R7", vec_a(), 4'b1000);

      // parking and prompt reuse without a request
      go_owned();
      step(0, 0, 1, 0);
      check("R8", vec_a(), 4'b0101);
      check("R11", {req_b, busy_b, lock_b, grant_b}, 4'b0000);
      step(0, 0, 1, 1);
      check("R8", vec_a(), 4'b0101);
      step(1, 0, 1, 0);
      check("R9", vec_a(), 4'b0101);
      step(0, 0, 1, 0);
      step(0, 0, 0, 0);
      check("R10", vec_a(), 4'b0000);

      // sweeps: src 0 = owned, 1 = locked, 2 = parked
      for (int src = 0; src < 3; src++) begin
         for (int c = 0; c < 16; c++) begin
            logic r, l, g, b;
            {r, l, g, b} = c[3:0];
            go_owned();
            if (src == 1) step(1, 1, 1, 0);
            if (src == 2) step(0, 0, 1, 0);
            step(r, l, g, b);
            check(tag_for(src == 1, r, l, g, src), vec_a(),
                  exp_after(src == 1, r, l, g));
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule